// File: doc/BRIEF.md
# Streaming Four-Tap Symbol Mismatch Correlator

This block compares a stream of symbols against a short reference pattern and reports, for every position in the stream, how many taps disagree. Tap k holds a reference symbol a_k and is lined up with the symbol that arrived k samples before the newest one. Each tap scores 1 when its stored symbol and its stream symbol differ, and 0 when they are equal. The result is the number of differing taps: 0 means the last four symbols match the pattern exactly.

The stream symbols move from tap to tap through registers. The running partial count moves in step with them, so that each tap adds one comparison to the count and registers it. Each register-to-register path therefore holds at most one comparator and one small adder, never the whole chain of adders. Reference symbols are written one tap at a time through an indexed port while the stream is idle. A result is marked valid only when all four samples behind it were presented as valid on consecutive cycles.

Top module: `mismatch_correlator`

## Requirements
- R1: While reset is asserted and directly after it is released, out_valid is 0 and out_count is 0.
- R2: For a valid window ending at sample x_t, out_count equals the number of taps k (0..3) where the sample presented k cycles before x_t differs from reference a_k, with a_k being the value written with ref_sel = k.
- R3: The result for a sample presented on in_valid/in_sym before clock edge E appears on the outputs after clock edge E+4 and stays there until the following edge.
- R4: out_valid is 1 only for a window whose four samples were all presented with in_valid = 1 on four consecutive cycles. A single bubble suppresses every window that contains it.
- R5: out_count lies between 0 and 4: it is 0 when all four taps match and 4 when none match.
- R6: Whenever out_valid is 0, out_count is 0.
- R7: A cycle with ref_we = 1 loads ref_val into tap ref_sel only. Later windows use the new value and the other taps keep their values.
- R8: Reset clears every reference symbol to zero.
- R9: Windows presented back to back give one result per cycle, with no gaps.
- R10: All bits of a symbol take part in the comparison. A difference in the most significant bit alone counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks in_sym as a real sample this cycle |
| in_sym | input | SYM_W | Incoming stream symbol |
| ref_we | input | 1 | Writes ref_val into the tap chosen by ref_sel |
| ref_sel | input | clog2(TAPS) | Tap index for a reference write |
| ref_val | input | SYM_W | Reference symbol to store |
| out_valid | output | 1 | out_count holds a complete window result |
| out_count | output | clog2(TAPS+1) | Number of mismatching taps |

## Verification
A wrong symbol in one stage of the delay line shows up as a count that is off by one. It can affect up to four consecutive results, and the first bad result appears no later than four cycles after the error entered the line. A stuck or lost valid flag either hides a result whose window was complete or releases one across a bubble. Both cases are visible within one latency of the affected sample. A reference register that takes the wrong value, or that changes without a write, shifts every later count on windows where that tap's sample matches or differs. The bench therefore runs streams whose windows match, half match and fully differ, against several reference sets.

// File: rtl/corr_pkg.sv
package corr_pkg;

   // Upper bound accepted for the tap count by elaboration checks.
   localparam int unsigned CORR_TAPS_MAX = 32;

   // Width needed to hold a count from 0 up to taps inclusive.
   function automatic int unsigned corr_cnt_width(input int unsigned taps);
      return $clog2(taps + 1);
   endfunction

   // Registers a stream symbol crosses between two neighbouring taps.
   localparam int unsigned CORR_HOP_REGS = 2;

endpackage

// File: rtl/corr_ref_bank.sv
module corr_ref_bank #(
   parameter int unsigned SYM_W = 8,
   parameter int unsigned TAPS  = 4,
   localparam int unsigned SEL_W = $clog2(TAPS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [SEL_W-1:0]        sel,
   input  logic [SYM_W-1:0]        wdata,
   output logic [TAPS*SYM_W-1:0]   refs_flat
);

   for (genvar k = 0; k < TAPS; k++) begin : g_ref
      logic [SYM_W-1:0] ref_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ref_q <= '0;
         end else if (we && (sel == SEL_W'(k))) begin
            ref_q <= wdata;
         end
      end

      assign refs_flat[k*SYM_W +: SYM_W] = ref_q;
   end

   // R7
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(refs_flat));

endmodule

// File: rtl/corr_xline.sv
module corr_xline #(
   parameter int unsigned SYM_W = 8,
   parameter int unsigned TAPS  = 4,
   parameter int unsigned HOP   = 2,
   localparam int unsigned NSTG = 1 + HOP * (TAPS - 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [SYM_W-1:0]        in_sym,
   output logic [TAPS*SYM_W-1:0]   tap_sym,
   output logic [TAPS-1:0]         tap_ok
);

   logic [SYM_W-1:0] st_sym [NSTG];
   logic             st_ok  [NSTG];

   for (genvar i = 0; i < NSTG; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_sym[0] <= '0;
               st_ok[0]  <= 1'b0;
            end else begin
               st_sym[0] <= in_valid ? in_sym : '0;
               st_ok[0]  <= in_valid;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_sym[i] <= '0;
               st_ok[i]  <= 1'b0;
            end else begin
               st_sym[i] <= st_sym[i-1];
               st_ok[i]  <= st_ok[i-1];
            end
         end
      end
   end

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign tap_sym[k*SYM_W +: SYM_W] = st_sym[HOP*k];
      assign tap_ok[k]                 = st_ok[HOP*k];
   end

endmodule

// File: rtl/corr_cell.sv
module corr_cell #(
   parameter int unsigned SYM_W = 8,
   parameter int unsigned SUM_W = 3,
   parameter int unsigned IDX   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SYM_W-1:0]  x_sym,
   input  logic              x_ok,
   input  logic [SYM_W-1:0]  ref_sym,
   input  logic [SUM_W-1:0]  sum_in,
   input  logic              ok_in,
   output logic [SUM_W-1:0]  sum_q,
   output logic              ok_q
);

   logic             live;
   logic [SUM_W-1:0] bump;

   assign live = ok_in & x_ok;
   assign bump = SUM_W'(x_sym != ref_sym);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         ok_q  <= 1'b0;
      end else begin
         ok_q  <= live;
         sum_q <= live ? (sum_in + bump) : '0;
      end
   end

   // R5
   psum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_q |-> (int'(sum_q) <= int'(IDX) + 1));

endmodule

// File: rtl/mismatch_correlator.sv
module mismatch_correlator
   import corr_pkg::*;
#(
   parameter int unsigned SYM_W = 8,
   parameter int unsigned TAPS  = 4,
   localparam int unsigned SEL_W = $clog2(TAPS),
   localparam int unsigned CNT_W = corr_cnt_width(TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SYM_W-1:0]  in_sym,
   input  logic              ref_we,
   input  logic [SEL_W-1:0]  ref_sel,
   input  logic [SYM_W-1:0]  ref_val,
   output logic              out_valid,
   output logic [CNT_W-1:0]  out_count
);

   if (TAPS < 2 || TAPS > CORR_TAPS_MAX) begin : g_bad_taps
      $error("mismatch_correlator: TAPS out of supported range");
   end
   if (SYM_W < 1) begin : g_bad_sym
      $error("mismatch_correlator: SYM_W must be at least 1");
   end

   logic [TAPS*SYM_W-1:0] refs_flat;
   logic [TAPS*SYM_W-1:0] tap_sym;
   logic [TAPS-1:0]       tap_ok;
   logic [CNT_W-1:0]      sum_w [TAPS+1];
   logic                  ok_w  [TAPS+1];

   corr_ref_bank #(.SYM_W(SYM_W), .TAPS(TAPS)) u_refs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (ref_we),
      .sel       (ref_sel),
      .wdata     (ref_val),
      .refs_flat (refs_flat)
   );

   corr_xline #(.SYM_W(SYM_W), .TAPS(TAPS), .HOP(CORR_HOP_REGS)) u_xline (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sym   (in_sym),
      .tap_sym  (tap_sym),
      .tap_ok   (tap_ok)
   );

   assign sum_w[0] = '0;
   assign ok_w[0]  = 1'b1;

   for (genvar k = 0; k < TAPS; k++) begin : g_cell
      corr_cell #(.SYM_W(SYM_W), .SUM_W(CNT_W), .IDX(k)) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .x_sym   (tap_sym[k*SYM_W +: SYM_W]),
         .x_ok    (tap_ok[k]),
         .ref_sym (refs_flat[k*SYM_W +: SYM_W]),
         .sum_in  (sum_w[k]),
         .ok_in   (ok_w[k]),
         .sum_q   (sum_w[k+1]),
         .ok_q    (ok_w[k+1])
      );
   end

   assign out_valid = ok_w[TAPS];
   assign out_count = sum_w[TAPS];

   // R5
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_count) <= int'(TAPS)));

   // R6
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_count == '0));

endmodule

// File: tb/mismatch_correlator_bench.sv
module mismatch_correlator_bench;

   localparam int unsigned SYM_W = 8;
   localparam int unsigned TAPS  = 4;
   localparam int unsigned SEL_W = 2;
   localparam int unsigned CNT_W = 3;
   localparam time CLK_P = 10ns;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [SYM_W-1:0] in_sym = '0;
   logic             ref_we = 1'b0;
   logic [SEL_W-1:0] ref_sel = '0;
   logic [SYM_W-1:0] ref_val = '0;
   logic             out_valid;
   logic [CNT_W-1:0] out_count;

   mismatch_correlator #(.SYM_W(SYM_W), .TAPS(TAPS)) u_mismatch_correlator (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sym    (in_sym),
      .ref_we    (ref_we),
      .ref_sel   (ref_sel),
      .ref_val   (ref_val),
      .out_valid (out_valid),
      .out_count (out_count)
   );

   always #(CLK_P/2) clk = ~clk;

   typedef struct {
      int due;
      int cnt;
   } exp_t;

   exp_t             sb_q[$];
   int               cyc = 0;
   int               n_chk = 0;
   int               n_err = 0;
   bit               mon_en = 1'b0;
   string            cur_tag = "R2";
   logic [SYM_W-1:0] mref [TAPS];
   logic [SYM_W-1:0] hs   [TAPS];
   bit               hv   [TAPS];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit good, input string tag, input int act, input int exp);
      n_chk++;
      if (!good) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
      end
   endtask

   // Reference model step: shift the presented sample into the history,
   // and queue the expected count when a complete window is formed.
   task automatic model_step(input bit v, input logic [SYM_W-1:0] s);
      bit win;
      int n;
      for (int k = TAPS - 1; k > 0; k--) begin
         hv[k] = hv[k-1];
         hs[k] = hs[k-1];
      end
      hv[0] = v;
      hs[0] = s;
      win = 1'b1;
      n = 0;
      for (int k = 0; k < TAPS; k++) begin
         win = win & hv[k];
         if (hs[k] != mref[k]) n++;
      end
      if (win) sb_q.push_back('{due: cyc + TAPS + 1, cnt: n});
   endtask

   task automatic send(input bit v, input logic [SYM_W-1:0] s);
      @(negedge clk);
      ref_we   = 1'b0;
      in_valid = v;
      in_sym   = s;
      model_step(v, s);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) send(1'b0, '0);
   endtask

   task automatic wr_ref(input int k, input logic [SYM_W-1:0] v);
      @(negedge clk);
      in_valid = 1'b0;
      in_sym   = '0;
      ref_we   = 1'b1;
      ref_sel  = SEL_W'(k);
      ref_val  = v;
      model_step(1'b0, '0);
      mref[k] = v;
   endtask

   // Monitor: every cycle either a queued result is due or the output is idle.
   always @(negedge clk) begin
      if (mon_en) begin
         if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            // R3 result present exactly at its due cycle
            chk(out_valid === 1'b1, "R3", int'(out_valid), 1);
            chk(int'(out_count) == sb_q[0].cnt, cur_tag, int'(out_count), sb_q[0].cnt);
            void'(sb_q.pop_front());
         end else begin
            // R4 no result without a complete window; R6 idle count is zero
            chk(out_valid === 1'b0, "R4", int'(out_valid), 0);
            chk(out_count == '0, "R6", int'(out_count), 0);
         end
      end
   end

   function automatic logic [SYM_W-1:0] pick(input int i);
      int j;
      j = (i * 3 + i / 2) % (TAPS + 1);
      return (j < TAPS) ? mref[j] : 8'hFF;
   endfunction

   initial begin
      for (int k = 0; k < TAPS; k++) begin
         mref[k] = '0;
         hs[k]   = '0;
         hv[k]   = 1'b0;
      end
      repeat (3) @(negedge clk);
      // R1 outputs quiet during reset
      chk(out_valid === 1'b0 && out_count == '0, "R1", int'(out_count), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 outputs quiet right after release
      chk(out_valid === 1'b0 && out_count == '0, "R1", int'(out_valid), 0);
      mon_en = 1'b1;

      // R8: references reset to zero, so a zero stream matches fully
      cur_tag = "R8";
      for (int i = 0; i < 6; i++) send(1'b1, 8'h00);
      send(1'b1, 8'h01);
      send(1'b1, 8'h00);
      idle(TAPS + 2);

      // R7: load a full reference set
      wr_ref(0, 8'h11);
      wr_ref(1, 8'h22);
      wr_ref(2, 8'h33);
      wr_ref(3, 8'h44);
      idle(1);

      // R5: exact match then full mismatch
      cur_tag = "R5";
      send(1'b1, 8'h44); send(1'b1, 8'h33); send(1'b1, 8'h22); send(1'b1, 8'h11);
      send(1'b1, 8'h00); send(1'b1, 8'h00); send(1'b1, 8'h00); send(1'b1, 8'h00);

      // R9 / R2: back-to-back mixed windows
      cur_tag = "R9";
      for (int i = 0; i < 16; i++) send(1'b1, pick(i));

      // R10: MSB-only differences count as mismatches
      cur_tag = "R10";
      send(1'b1, 8'h44 ^ 8'h80); send(1'b1, 8'h33 ^ 8'h80);
      send(1'b1, 8'h22 ^ 8'h80); send(1'b1, 8'h11 ^ 8'h80);
      send(1'b1, 8'h44); send(1'b1, 8'h33 ^ 8'h80); send(1'b1, 8'h22); send(1'b1, 8'h11);

      // R4: bubbles break windows
      cur_tag = "R4";
      send(1'b1, 8'h44); send(1'b1, 8'h33); send(1'b0, 8'h22); send(1'b1, 8'h22);
      send(1'b1, 8'h11); send(1'b1, 8'h44); send(1'b1, 8'h33); send(1'b0, 8'h00);
      send(1'b1, 8'h33); send(1'b1, 8'h22); send(1'b1, 8'h11); send(1'b1, 8'h11);
      idle(TAPS + 2);

      // R7: rewrite a single tap, others keep their values
      cur_tag = "R7";
      wr_ref(2, 8'hA5);
      idle(1);
      send(1'b1, 8'h44); send(1'b1, 8'h33); send(1'b1, 8'hA5); send(1'b1, 8'h11);
      send(1'b1, 8'h44); send(1'b1, 8'hA5); send(1'b1, 8'h22); send(1'b1, 8'h11);

      // R2: general windows against the updated set
      cur_tag = "R2";
      for (int i = 0; i < 12; i++) send(1'b1, pick(i + 5));
      idle(TAPS + 3);

      // R3: every queued result has been delivered
      chk(sb_q.size() == 0, "R3", sb_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule